// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This block runs the power-on bring-up of a PCIe root-port link on the controller side. A single start pulse begins the sequence. The block first looks at the training state reported by the MAC. If the link is already in L0, nothing is programmed and success is reported at once. Otherwise the block opens the override that lets normally read-only fields be written. It then writes the requested target speed into two 4-bit fields, the link-capability field first and the link-control-2 field second, and closes the override again.

After that the block raises the training enable and waits for L0. If L0 does not arrive within a training window, the block reports a timeout. If L0 does arrive, the block waits a further settle window so that speed negotiation can finish. It then reports link up and captures the negotiated speed and width from the link status word. The MAC, the PHY and the training state machine sit outside the block and appear only as inputs.

Both windows are cycle counts derived from the clock frequency. By default the training window is 100 ms and the settle window is 100 µs.

Top module: `pcie_link_bringup`

## Requirements
- R1: During and after a synchronous reset, all of these outputs are 0: `ltssm_en`, `ro_unlock`, `fld_wr_valid`, `fld_wr_sel`, `fld_wr_speed`, `done`, `link_up`, `timeout_err`, `neg_speed` and `neg_width`.
- R2: A start sampled while idle, with the link in L0, makes `done` and `link_up` 1 one cycle later. This case performs no override, no field write and no change to `ltssm_en`.
- R3: A start sampled while idle, with the link not in L0, drives the following, one cycle each:
  - first cycle after the start: `ro_unlock` alone;
  - second cycle: a field write with `fld_wr_sel`=0 (link-capability field), `ro_unlock` still high;
  - third cycle: a field write with `fld_wr_sel`=1 (link-control-2 field), `ro_unlock` still high;
  - fourth cycle: no write and `ro_unlock` low.

  `fld_wr_speed` carries the requested speed (1 = Gen1, 2 = Gen2, 3 = Gen3) during writes and is 0 otherwise. A write never occurs with `ro_unlock` low.
- R4: `ltssm_en` rises in the cycle after the override is closed. It then stays 1 until reset.
- R5: The link counts as in L0 when bits 4:0 of `ltssm_state` equal 5'h11. Any higher bits are ignored.
- R6: If none of the first TRAIN_CYC samples taken after `ltssm_en` rises shows L0, the block makes `done`=1, `timeout_err`=1 and `link_up`=0 right after the last sample. L0 on the last sample still counts as success.
- R7: Once L0 is sampled during training, `done` and `link_up` become 1 exactly SETTLE_CYC+1 cycles later. The result stands even if L0 is lost during the settle window.
- R8: `neg_speed` is taken from `link_status[19:16]` and `neg_width` from `link_status[23:20]`, sampled in the same cycle that success is decided. Both then stay constant until the next accepted start. Both are 0 after a timeout.
- R9: A start while a sequence is running has no effect. An accepted start clears `done`, `link_up`, `timeout_err`, `neg_speed` and `neg_width`.
- R10: TRAIN_CYC = (CLK_FREQ_HZ/1e6)·TRAIN_TIMEOUT_US and SETTLE_CYC = (CLK_FREQ_HZ/1e6)·SETTLE_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts one bring-up sequence when idle |
| req_speed | input | SPD_W | Requested maximum link speed |
| ltssm_state | input | LTSSM_W | Training state from the MAC |
| link_status | input | STAT_W | Link status word from the MAC |
| ro_unlock | output | 1 | Override that permits writes to read-only fields |
| fld_wr_valid | output | 1 | Target-speed field write strobe |
| fld_wr_sel | output | 1 | 0 = link-capability field, 1 = link-control-2 field |
| fld_wr_speed | output | SPD_W | Value written into the selected field |
| ltssm_en | output | 1 | Training enable to the MAC |
| done | output | 1 | Sequence finished; held until next accepted start |
| link_up | output | 1 | Link reached L0 and settled |
| timeout_err | output | 1 | L0 not reached in the training window |
| neg_speed | output | 4 | Negotiated speed |
| neg_width | output | 4 | Negotiated width |

## Verification
The bench builds the block with CLK_FREQ_HZ = 2 MHz, TRAIN_TIMEOUT_US = 40 and SETTLE_US = 5. This gives an 80-cycle training window and a 10-cycle settle window, so the timeout and the success cases just inside and just outside the training window can all be reached in a few hundred cycles. A behavioural model runs alongside the design and checks every output on every cycle. The stimulus covers these cases:
- the already-in-L0 shortcut;
- an L0 code with an extra high bit set;
- near-miss training codes;
- loss of L0 during the settle window;
- start pulses arriving while a sequence is running.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNLOCK,
      ST_WR_CAP,
      ST_WR_CTL2,
      ST_LOCK,
      ST_TRAIN,
      ST_SETTLE
   } seq_state_e;

   localparam logic [4:0] L0_CODE = 5'h11;

   localparam logic SEL_LINK_CAP  = 1'b0;
   localparam logic SEL_LINK_CTL2 = 1'b1;

endpackage

// File: rtl/lbs_timer.sv
module lbs_timer #(
   parameter int MAX_VAL = 1000,
   localparam int CNT_W  = (MAX_VAL < 1) ? 1 : $clog2(MAX_VAL + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);

   if (MAX_VAL == 0) begin : g_no_counter
      logic in_unused;
      assign in_unused = ^{clk, rst, load, load_val, dec};
      assign zero      = 1'b1;
   end else begin : g_counter
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst)
            cnt_q <= '0;
         else if (load)
            cnt_q <= load_val;
         else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
      end

      assign zero = (cnt_q == '0);

      // R10: a load sets the exact count used for the window
      a_r10_load_takes: assert property (@(posedge clk) disable iff (rst)
         load |=> (cnt_q == $past(load_val)));

      // R10: counting only moves downward by one
      a_r10_dec_step: assert property (@(posedge clk) disable iff (rst)
         (!load && dec && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   end

endmodule

// File: rtl/lbs_status_cap.sv
module lbs_status_cap #(
   parameter int STAT_W    = 32,
   parameter int SPEED_LSB = 16,
   parameter int WIDTH_LSB = 20,
   parameter int FIELD_W   = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clear,
   input  logic               capture,
   input  logic [STAT_W-1:0]  link_status,
   output logic [FIELD_W-1:0] speed,
   output logic [FIELD_W-1:0] width
);

   logic stat_unused;
   assign stat_unused = ^link_status;

   always_ff @(posedge clk) begin
      if (rst) begin
         speed <= '0;
         width <= '0;
      end else if (capture) begin
         speed <= link_status[SPEED_LSB +: FIELD_W];
         width <= link_status[WIDTH_LSB +: FIELD_W];
      end else if (clear) begin
         speed <= '0;
         width <= '0;
      end
   end

   // R8: captured fields hold between events
   a_r8_fields_hold: assert property (@(posedge clk) disable iff (rst)
      (!clear && !capture) |=> ($stable(speed) && $stable(width)));

   // R8: capture takes the word seen at the deciding edge
   a_r8_capture_src: assert property (@(posedge clk) disable iff (rst)
      capture |=> (speed == $past(link_status[SPEED_LSB +: FIELD_W])));

endmodule

// File: rtl/pcie_link_bringup.sv
module pcie_link_bringup
   import lbs_pkg::*;
#(
   parameter int CLK_FREQ_HZ      = 200_000_000,
   parameter int TRAIN_TIMEOUT_US = 100_000,
   parameter int SETTLE_US        = 100,
   parameter int SPD_W            = 4,
   parameter int LTSSM_W          = 6,
   parameter int STAT_W           = 32,
   parameter int SPEED_LSB        = 16,
   parameter int WIDTH_LSB        = 20
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [SPD_W-1:0]   req_speed,
   input  logic [LTSSM_W-1:0] ltssm_state,
   input  logic [STAT_W-1:0]  link_status,
   output logic               ro_unlock,
   output logic               fld_wr_valid,
   output logic               fld_wr_sel,
   output logic [SPD_W-1:0]   fld_wr_speed,
   output logic               ltssm_en,
   output logic               done,
   output logic               link_up,
   output logic               timeout_err,
   output logic [3:0]         neg_speed,
   output logic [3:0]         neg_width
);

   localparam int FIELD_W    = 4;
   localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
   localparam int TRAIN_CYC  = CYC_PER_US * TRAIN_TIMEOUT_US;
   localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
   localparam int MAX_CYC    = (TRAIN_CYC > SETTLE_CYC) ? TRAIN_CYC : SETTLE_CYC;
   localparam int TMR_MAX    = MAX_CYC - 1;
   localparam int TMR_W      = (TMR_MAX < 1) ? 1 : $clog2(TMR_MAX + 1);

   if (CLK_FREQ_HZ % 1_000_000 != 0 || CLK_FREQ_HZ < 1_000_000) begin : g_bad_clk
      $error("CLK_FREQ_HZ must be a whole number of MHz");
   end
   if (TRAIN_TIMEOUT_US < 1 || SETTLE_US < 1) begin : g_bad_win
      $error("window lengths must be at least 1 us");
   end
   if (LTSSM_W < 5) begin : g_bad_ltssm
      $error("LTSSM_W must cover the 5-bit state code");
   end
   if (STAT_W < WIDTH_LSB + FIELD_W || STAT_W < SPEED_LSB + FIELD_W) begin : g_bad_stat
      $error("link status word too narrow for its fields");
   end
   if (SPD_W < 2) begin : g_bad_spd
      $error("SPD_W must hold Gen3");
   end

   seq_state_e       state_q;
   logic [SPD_W-1:0] req_q;
   logic             en_q, done_q, up_q, terr_q;
   logic             is_l0, tmr_zero, tmr_load, tmr_dec;
   logic [TMR_W-1:0] tmr_val;
   logic             accept, cap_now;
   logic             ltssm_unused;

   assign ltssm_unused = ^ltssm_state;
   assign is_l0        = (ltssm_state[4:0] == L0_CODE);
   assign accept       = (state_q == ST_IDLE) && start;

   // sequence controller
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         req_q   <= '0;
         en_q    <= 1'b0;
         done_q  <= 1'b0;
         up_q    <= 1'b0;
         terr_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  terr_q <= 1'b0;
                  if (is_l0) begin
                     done_q <= 1'b1;
                     up_q   <= 1'b1;
                  end else begin
                     done_q  <= 1'b0;
                     up_q    <= 1'b0;
                     req_q   <= req_speed;
                     state_q <= ST_UNLOCK;
                  end
               end
            end
            ST_UNLOCK:  state_q <= ST_WR_CAP;
            ST_WR_CAP:  state_q <= ST_WR_CTL2;
            ST_WR_CTL2: state_q <= ST_LOCK;
            ST_LOCK: begin
               en_q    <= 1'b1;
               state_q <= ST_TRAIN;
            end
            ST_TRAIN: begin
               if (is_l0) begin
                  state_q <= ST_SETTLE;
               end else if (tmr_zero) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  terr_q  <= 1'b1;
               end
            end
            ST_SETTLE: begin
               if (tmr_zero) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  up_q    <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // window timer control
   always_comb begin
      tmr_load = 1'b0;
      tmr_dec  = 1'b0;
      tmr_val  = TMR_W'(TRAIN_CYC - 1);
      if (state_q == ST_LOCK) begin
         tmr_load = 1'b1;
      end else if (state_q == ST_TRAIN) begin
         if (is_l0) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(SETTLE_CYC - 1);
         end else begin
            tmr_dec = 1'b1;
         end
      end else if (state_q == ST_SETTLE) begin
         tmr_dec = 1'b1;
      end
   end

   lbs_timer #(.MAX_VAL(TMR_MAX)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .zero     (tmr_zero)
   );

   assign cap_now = (accept && is_l0) || ((state_q == ST_SETTLE) && tmr_zero);

   lbs_status_cap #(
      .STAT_W    (STAT_W),
      .SPEED_LSB (SPEED_LSB),
      .WIDTH_LSB (WIDTH_LSB),
      .FIELD_W   (FIELD_W)
   ) u_status (
      .clk         (clk),
      .rst         (rst),
      .clear       (accept),
      .capture     (cap_now),
      .link_status (link_status),
      .speed       (neg_speed),
      .width       (neg_width)
   );

   assign ro_unlock    = (state_q == ST_UNLOCK) || (state_q == ST_WR_CAP) ||
                         (state_q == ST_WR_CTL2);
   assign fld_wr_valid = (state_q == ST_WR_CAP) || (state_q == ST_WR_CTL2);
   assign fld_wr_sel   = (state_q == ST_WR_CTL2) ? SEL_LINK_CTL2 : SEL_LINK_CAP;
   assign fld_wr_speed = fld_wr_valid ? req_q : '0;
   assign ltssm_en     = en_q;
   assign done         = done_q;
   assign link_up      = up_q;
   assign timeout_err  = terr_q;

   // R3: field writes only happen under the override
   a_r3_write_needs_unlock: assert property (@(posedge clk) disable iff (rst)
      fld_wr_valid |-> ro_unlock);

   // R3: the capability field is written before the control-2 field
   a_r3_field_order: assert property (@(posedge clk) disable iff (rst)
      (fld_wr_valid && fld_wr_sel == SEL_LINK_CTL2) |-> $past(fld_wr_valid && fld_wr_sel == SEL_LINK_CAP));

   // R4: training starts only with the override closed, then stays on
   a_r4_en_after_lock: assert property (@(posedge clk) disable iff (rst)
      $rose(ltssm_en) |-> (!ro_unlock && !$past(ro_unlock)));
   a_r4_en_sticky: assert property (@(posedge clk) disable iff (rst)
      ltssm_en |=> ltssm_en);

   // R6: a timeout never reports link up
   a_r6_timeout_shape: assert property (@(posedge clk) disable iff (rst)
      timeout_err |-> (done && !link_up));

   // R7: link up is only reported as a finished result
   a_r7_up_is_done: assert property (@(posedge clk) disable iff (rst)
      link_up |-> done);

   // R9: results hold while no start is given
   a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> ($stable(done) && $stable(link_up) && $stable(timeout_err)));

endmodule

// File: tb/tb_pcie_link_bringup.sv
`timescale 1ns/1ps
module tb_pcie_link_bringup;

   localparam int FREQ   = 2_000_000;
   localparam int TR_US  = 40;
   localparam int ST_US  = 5;
   localparam int TR_CYC = 80;   // 2 cycles/us * 40 us
   localparam int ST_CYC = 10;   // 2 cycles/us * 5 us

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [3:0]  req_speed = 4'd2;
   logic [5:0]  ltssm_state = 6'h00;
   logic [31:0] link_status = 32'h0;
   logic        ro_unlock, fld_wr_valid, fld_wr_sel, ltssm_en, done, link_up, timeout_err;
   logic [3:0]  fld_wr_speed, neg_speed, neg_width;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pcie_link_bringup #(
      .CLK_FREQ_HZ(FREQ), .TRAIN_TIMEOUT_US(TR_US), .SETTLE_US(ST_US)
   ) dut (
      .clk(clk), .rst(rst), .start(start), .req_speed(req_speed),
      .ltssm_state(ltssm_state), .link_status(link_status),
      .ro_unlock(ro_unlock), .fld_wr_valid(fld_wr_valid), .fld_wr_sel(fld_wr_sel),
      .fld_wr_speed(fld_wr_speed), .ltssm_en(ltssm_en), .done(done),
      .link_up(link_up), .timeout_err(timeout_err),
      .neg_speed(neg_speed), .neg_width(neg_width)
   );

   // behavioural reference: phase 0 idle, 1 programming, 2 training, 3 settling
   int       m_phase = 0, m_k = 0, m_t = 0, m_s = 0;
   logic     m_en = 0, m_done = 0, m_up = 0, m_terr = 0;
   logic [3:0] m_spd = 0, m_wid = 0, m_req = 0;

   function automatic bit in_l0(logic [5:0] s);
      return s[4:0] == 5'h11;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_phase = 0; m_en = 0; m_done = 0; m_up = 0; m_terr = 0;
         m_spd = 0; m_wid = 0; m_req = 0;
      end else begin
         case (m_phase)
            0: if (start) begin
                  m_done = 0; m_up = 0; m_terr = 0; m_spd = 0; m_wid = 0;
                  if (in_l0(ltssm_state)) begin
                     m_done = 1; m_up = 1;
                     m_spd = link_status[19:16]; m_wid = link_status[23:20];
                  end else begin
                     m_phase = 1; m_k = 1; m_req = req_speed;
                  end
               end
            1: if (m_k == 4) begin m_phase = 2; m_en = 1; m_t = 0; end
               else m_k++;
            2: if (in_l0(ltssm_state)) begin m_phase = 3; m_s = 0; end
               else begin
                  m_t++;
                  if (m_t == TR_CYC) begin m_phase = 0; m_done = 1; m_terr = 1; end
               end
            default: begin
               m_s++;
               if (m_s == ST_CYC) begin
                  m_phase = 0; m_done = 1; m_up = 1;
                  m_spd = link_status[19:16]; m_wid = link_status[23:20];
               end
            end
         endcase
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_on && !finished) begin
         logic wv;
         wv = (m_phase == 1) && (m_k == 2 || m_k == 3);
         chk(32'(ro_unlock), 32'((m_phase == 1) && m_k <= 3), "R3", "ro_unlock");
         chk(32'(fld_wr_valid), 32'(wv), "R3", "fld_wr_valid");
         chk(32'(fld_wr_sel), 32'((m_phase == 1) && m_k == 3), "R3", "fld_wr_sel");
         chk(32'(fld_wr_speed), wv ? 32'(m_req) : 32'h0, "R3", "fld_wr_speed");
         chk(32'(ltssm_en), 32'(m_en), "R4", "ltssm_en");
         chk(32'(done), 32'(m_done), "R7", "done");
         chk(32'(link_up), 32'(m_up), "R7", "link_up");
         chk(32'(timeout_err), 32'(m_terr), "R6", "timeout_err");
         chk(32'(neg_speed), 32'(m_spd), "R8", "neg_speed");
         chk(32'(neg_width), 32'(m_wid), "R8", "neg_width");
      end
   end

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      wait_cyc(3);
      chk(32'({ltssm_en, ro_unlock, fld_wr_valid, fld_wr_sel, done, link_up, timeout_err}),
          32'h0, "R1", "control outputs in reset");
      chk(32'({fld_wr_speed, neg_speed, neg_width}), 32'h0, "R1", "fields in reset");
      rst = 1'b0;
      cmp_on = 1'b1;
      wait_cyc(2);

      // R2: already in L0, no programming
      ltssm_state = 6'h11;
      link_status = 32'h0042_1234;
      pulse_start();
      chk(32'({done, link_up}), 32'h3, "R2", "immediate done/link_up");
      chk(32'({ltssm_en, ro_unlock}), 32'h0, "R2", "no enable, no override");
      chk(32'({neg_width, neg_speed}), 32'h42, "R8", "captured width/speed");
      wait_cyc(3);

      // normal run, near-miss codes, then L0 with a high bit set (R5)
      ltssm_state = 6'h03;
      req_speed = 4'd2;
      link_status = 32'h0082_0000;
      pulse_start();
      chk(32'(ro_unlock), 32'h1, "R3", "override opens first");
      wait_cyc(8);
      ltssm_state = 6'h10; wait_cyc(2);
      ltssm_state = 6'h12; wait_cyc(2);
      chk(32'(done), 32'h0, "R5", "near-miss codes are not L0");
      ltssm_state = 6'h31;
      wait_cyc(ST_CYC + 1);
      chk(32'({done, link_up}), 32'h3, "R7", "success after settle");
      chk(32'({neg_width, neg_speed}), 32'h82, "R8", "negotiated fields");
      chk(32'(ltssm_en), 32'h1, "R4", "enable stays on");
      link_status = 32'h00F7_0000;
      wait_cyc(3);
      chk(32'({neg_width, neg_speed}), 32'h82, "R8", "fields hold after done");

      // L0 lost during settle (R7), Gen3 request
      ltssm_state = 6'h00;
      req_speed = 4'd3;
      pulse_start();
      wait_cyc(10);
      ltssm_state = 6'h11; wait_cyc(1);
      ltssm_state = 6'h05;
      wait_cyc(ST_CYC + 2);
      chk(32'(link_up), 32'h1, "R7", "settle not cancelled by L0 loss");

      // timeout with ignored starts (R6, R9)
      req_speed = 4'd1;
      pulse_start();
      wait_cyc(20);
      pulse_start();
      wait_cyc(20);
      pulse_start();
      wait_cyc(TR_CYC);
      chk(32'({done, timeout_err, link_up}), 32'h6, "R6", "timeout result");
      chk(32'({neg_width, neg_speed}), 32'h0, "R8", "fields zero after timeout");

      // L0 on the last training sample still succeeds (R6, R10)
      link_status = 32'h0013_0000;
      pulse_start();
      chk(32'(done), 32'h0, "R9", "start clears previous result");
      wait_cyc(4 + TR_CYC - 1);
      ltssm_state = 6'h11; wait_cyc(1);
      ltssm_state = 6'h05;
      wait_cyc(ST_CYC + 2);
      chk(32'({link_up, timeout_err}), 32'h2, "R10", "L0 on last sample");

      // L0 one sample too late fails (R6, R10)
      pulse_start();
      wait_cyc(4 + TR_CYC);
      chk(32'({done, timeout_err}), 32'h3, "R10", "window length exact");
      ltssm_state = 6'h11;
      wait_cyc(3);
      chk(32'(link_up), 32'h0, "R6", "late L0 does not change result");

      wait_cyc(2);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule